// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block models the read side of a pipelined synchronous DRAM. Each clock it takes a command that is either a READ, carrying a bank and a starting column, or a no-operation. A READ starts a four-word burst. A burst counter walks the column through an aligned group of four. Each generated address travels through a latency pipeline two or three stages deep, and one word per cycle comes out of a small storage array onto the data bus together with a valid flag.

A READ may arrive on any cycle, to any bank. It cuts short the burst already in flight. Its own words then follow the last delivered word of the older burst with no idle cycle between them. If a READ arrives exactly four cycles after the previous one, the two bursts run end to end.

The latency is a static setting captured while reset is held. A load port fills the storage array, so that a test environment can place known data at every bank and column.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While reset is held and on the first cycle after it, `dq_valid` is 0 and `dq` is all zeros.
- R2: When `cas_lat3` was 0 at reset, a READ sampled on clock edge k places its first word on `dq`, with `dq_valid` high, just after edge k+1. The bus is therefore stable at edge k+2.
- R3: When `cas_lat3` was 1 at reset, that first word appears just after edge k+2, one cycle later than under R2.
- R4: An uninterrupted READ delivers exactly four words on four consecutive cycles with `dq_valid` high. `dq_valid` then returns to 0 if no later READ is pending.
- R5: The burst column keeps bits [3:2] of the start column. Bits [1:0] count up by one per word, modulo 4. Start 6, for example, yields 6, 7, 4, 5.
- R6: A READ issued while a burst is in flight truncates that burst. The older burst's undelivered words never appear on `dq`, and the new burst's first word follows on the very next cycle with no gap. A READ four cycles after the previous one continues that burst seamlessly.
- R7: Successive READs may target the same bank or different banks on consecutive cycles with no wait cycles. Each word is taken from the bank named by its own READ.
- R8: Whenever `dq_valid` is 0, `dq` is all zeros.
- R9: `cas_lat3` is captured only while `rst_n` is low. Changing it after reset leaves the latency unchanged.
- R10: A load (`ld_en` high) writes `ld_data` into the array at {`ld_bank`, `ld_col`}. A later READ that covers that column returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cas_lat3 | input | 1 | Latency select captured during reset: 0 means two cycles, 1 means three |
| cmd_read | input | 1 | High for a READ command in this cycle |
| cmd_bank | input | 2 | Bank of the READ |
| cmd_col | input | 4 | Starting column of the READ |
| ld_en | input | 1 | Write enable of the array load port |
| ld_bank | input | 2 | Bank of the word being loaded |
| ld_col | input | 4 | Column of the word being loaded |
| ld_data | input | 16 | Word to load |
| dq | output | 16 | Read data bus |
| dq_valid | output | 1 | High when `dq` holds a burst word |

## Verification
The bench targets the boundaries where a burst can leak or stall. A READ one cycle after another must leave exactly one word of the older burst; a design that finished the older burst would show stale columns where new-bank data belongs. A READ four cycles after its predecessor must join the two bursts without a hole, and a pipeline tap that is off by one would show up there as a dropped or doubled word. A start column of 6 exposes a counter that carries into bit 2 instead of wrapping. Toggling the latency input after reset catches a design that samples it continuously.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  localparam int BANK_W    = 2;
  localparam int COL_W     = 4;
  localparam int DATA_W    = 16;
  localparam int BURST_LEN = 4;
  localparam int MIN_CL    = 2;
  localparam int MAX_CL    = 3;
  localparam int OFF_W     = $clog2(BURST_LEN);
  localparam int SEL_W     = (MAX_CL > MIN_CL) ? $clog2(MAX_CL - MIN_CL + 1) : 1;
  localparam int ADDR_W    = BANK_W + COL_W;

  // One slot of the latency pipeline: an address that will become a bus word
  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } slot_t;

  // Column for word 'off' of a burst starting at 'start': low bits wrap
  function automatic logic [COL_W-1:0] burst_col(input logic [COL_W-1:0] start,
                                                 input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] low;
    low = start[OFF_W-1:0] + off;
    return {start[COL_W-1:OFF_W], low};
  endfunction
endpackage

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_read,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  output slot_t             issue
);
  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q;
  logic [OFF_W-1:0]  off_q;
  logic              burst_cont;   // named event: a continuation word is issued

  always_comb begin
    issue      = '0;
    burst_cont = act_q & ~cmd_read;
    if (cmd_read) begin
      issue.valid = 1'b1;
      issue.bank  = cmd_bank;
      issue.col   = cmd_col;
    end else if (act_q) begin
      issue.valid = 1'b1;
      issue.bank  = bank_q;
      issue.col   = burst_col(start_q, off_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      off_q   <= '0;
    end else if (cmd_read) begin
      act_q   <= 1'b1;
      bank_q  <= cmd_bank;
      start_q <= cmd_col;
      off_q   <= OFF_W'(1);
    end else if (act_q) begin
      off_q   <= off_q + OFF_W'(1);
      act_q   <= (off_q != OFF_W'(BURST_LEN - 1));
    end
  end

  // R5: a continuation word steps only the low column bits, modulo the burst
  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont |-> (issue.col[OFF_W-1:0] == OFF_W'($past(issue.col[OFF_W-1:0]) + 1'b1))
                && (issue.col[COL_W-1:OFF_W] == $past(issue.col[COL_W-1:OFF_W])));

  // R4: at most three continuation words follow a READ
  p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont && $past(burst_cont) && $past(burst_cont, 2) |=> !burst_cont);

  // R7: a continuation word stays in the bank of its READ
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont |-> issue.bank == $past(issue.bank));
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe
  import sdram_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] lat_sel,
  input  slot_t            in_slot,
  output slot_t            tap
);
  localparam int DEPTH = MAX_CL - 1;   // the final stage is the data register

  slot_t stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= in_slot;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  // lat_sel 0 selects the minimum latency
  assign tap = stg[lat_sel];

  // R2: latency two taps the address one register after issue
  p_cl2_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_sel == 0) && $past(in_slot.valid) |->
      tap.valid && tap.bank == $past(in_slot.bank) && tap.col == $past(in_slot.col));

  // R3: latency three taps it two registers after issue
  p_cl3_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_sel == 1) && $past(in_slot.valid, 2) |->
      tap.valid && tap.bank == $past(in_slot.bank, 2) && tap.col == $past(in_slot.col, 2));

  // R4: no slot appears at the tap unless one was issued at the right time
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tap.valid |-> ((lat_sel == 0) ? $past(in_slot.valid) : $past(in_slot.valid, 2)));
endmodule

// File: rtl/sdram_word_store.sv
module sdram_word_store
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [COL_W-1:0]  ld_col,
  input  logic [DATA_W-1:0] ld_data,
  input  slot_t             rd_slot,
  output logic [DATA_W-1:0] dq,
  output logic              dq_valid
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (ld_en) mem[{ld_bank, ld_col}] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq       <= '0;
      dq_valid <= 1'b0;
    end else begin
      dq_valid <= rd_slot.valid;
      dq       <= rd_slot.valid ? mem[{rd_slot.bank, rd_slot.col}] : '0;
    end
  end

  // R8: an idle bus carries zeros
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> dq == '0);

  // R1: the cycle after reset release shows an idle bus
  p_reset_idle_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> !dq_valid);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic              cmd_read,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              ld_en,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [COL_W-1:0]  ld_col,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] dq,
  output logic              dq_valid
);
  logic             cl3_q;
  logic [SEL_W-1:0] lat_sel;
  slot_t            issue;
  slot_t            tap;

  // Latency is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) cl3_q <= cas_lat3;
  end

  assign lat_sel = SEL_W'(cl3_q);

  sdram_burst_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_read (cmd_read),
    .cmd_bank (cmd_bank),
    .cmd_col  (cmd_col),
    .issue    (issue)
  );

  sdram_lat_pipe u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .lat_sel (lat_sel),
    .in_slot (issue),
    .tap     (tap)
  );

  sdram_word_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_bank  (ld_bank),
    .ld_col   (ld_col),
    .ld_data  (ld_data),
    .rd_slot  (tap),
    .dq       (dq),
    .dq_valid (dq_valid)
  );

  // R9: the latency setting cannot move once reset is released
  p_lat_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cl3_q));

  // R6: a READ is never lost; its word reaches the tap within the latency
  p_read_reaches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_read) && !cl3_q |-> tap.valid);
endmodule

// File: tb/sdram_rd_pipe_test.sv
module sdram_rd_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cas_lat3 = 1'b0;
  logic        cmd_read = 1'b0;
  logic [1:0]  cmd_bank = '0;
  logic [3:0]  cmd_col = '0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_bank = '0;
  logic [3:0]  ld_col = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] dq;
  logic        dq_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_rd_pipe uut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .cmd_read(cmd_read), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .ld_en(ld_en), .ld_bank(ld_bank), .ld_col(ld_col), .ld_data(ld_data),
    .dq(dq), .dq_valid(dq_valid)
  );

  // Stimulus per cycle: [6] READ, [5:4] bank, [3:0] start column
  localparam int N = 20;
  localparam logic [6:0] VEC [N] = '{
    7'b1000000, 7'h00, 7'h00, 7'h00, 7'h00,
    7'h00, 7'b1010110, 7'h00, 7'b1011001, 7'h00,
    7'h00, 7'h00, 7'b1101100, 7'b1110001, 7'b1001111,
    7'h00, 7'h00, 7'h00, 7'h00, 7'h00
  };

  function automatic logic [15:0] pattern(input int b, input int c);
    return 16'hA000 + 16'(b * 256 + c * 17);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_with(input bit cl3);
    cmd_read = 1'b0;
    rst_n    = 1'b0;
    cas_lat3 = cl3;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {15'b0, dq_valid}, 16'h0);
    chk("R1 dq in reset", dq, 16'h0);
    rst_n = 1'b1;
  endtask

  task automatic preload();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_bank = 2'(a / 16);
      ld_col  = 4'(a % 16);
      ld_data = pattern(a / 16, a % 16);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_table(input bit cl3);
    int lat;
    lat = cl3 ? 3 : 2;
    reset_with(cl3);
    preload();
    for (int i = 0; i < N + 7; i++) begin
      @(negedge clk);
      if (i > 0) begin
        int e;
        int off;
        int c;
        int b;
        bit ev;
        logic [15:0] ed;
        e   = i - 1;
        ev  = 1'b0;
        ed  = '0;
        off = 99;
        // newest READ whose data window has opened by edge e
        for (int r = e; r >= 0; r--) begin
          if (r < N && VEC[r][6] && (r + lat - 1 <= e) && off == 99) begin
            off = e - (r + lat - 1);
            b   = int'(VEC[r][5:4]);
            c   = int'(VEC[r][3:0]);
          end
        end
        if (off < 4) begin
          ev = 1'b1;
          ed = pattern(b, (c / 4) * 4 + ((c + off) % 4));
        end
        chk(cl3 ? "R3 R4 R6 valid" : "R2 R4 R6 valid", {15'b0, dq_valid}, {15'b0, ev});
        chk(ev ? "R5 R7 data" : "R8 idle data", dq, ed);
      end
      if (i < N) {cmd_read, cmd_bank, cmd_col} = VEC[i];
      else       {cmd_read, cmd_bank, cmd_col} = 7'h00;
    end
  endtask

  initial begin
    run_table(1'b0);
    run_table(1'b1);

    // R9: latency held at two although the select moves after reset
    reset_with(1'b0);
    @(negedge clk);
    cas_lat3 = 1'b1;
    @(negedge clk);
    {cmd_read, cmd_bank, cmd_col} = {1'b1, 2'd2, 4'd3};
    @(negedge clk);
    cmd_read = 1'b0;
    chk("R9 not early", {15'b0, dq_valid}, 16'h0);
    @(negedge clk);
    chk("R9 valid at two", {15'b0, dq_valid}, 16'h1);
    chk("R9 data at two", dq, pattern(2, 3));
    repeat (4) @(negedge clk);

    // R10: overwrite one word, then read through it
    ld_en = 1'b1; ld_bank = 2'd3; ld_col = 4'd7; ld_data = 16'h1234;
    @(negedge clk);
    ld_en = 1'b0;
    {cmd_read, cmd_bank, cmd_col} = {1'b1, 2'd3, 4'd5};
    @(negedge clk);
    cmd_read = 1'b0;
    @(negedge clk);
    chk("R10 first word", dq, pattern(3, 5));
    @(negedge clk);
    chk("R10 second word", dq, pattern(3, 6));
    @(negedge clk);
    chk("R10 loaded word", dq, 16'h1234);
    @(negedge clk);
    chk("R10 wrapped word", dq, pattern(3, 4));
    @(negedge clk);
    chk("R4 burst ended", {15'b0, dq_valid}, 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule